// File: doc/BRIEF.md
# Prioritized Overlay Window Generator

This block paints up to four rectangular background windows, each with an optional drop shadow, onto a character-cell overlay. It is given the position of the pixel being drawn: the character row and column, the pixel within the character cell and the line within the character row. For that pixel it decides which window body or shadow covers it, if any, and outputs a colour and a valid flag one clock later. Glyph drawing, borders and the final mix with the underlying video are done by other blocks.

Each window has inclusive row and column bounds in character units, a 3-bit colour and a shadow-enable bit. It also has two 2-bit codes that set how far its shadow reaches, in pixels to the right and in lines downward. All shadows share one 3-bit colour. The window enable bits are held in this block. A load strobe writes all of them at once, and a clear strobe zeroes all of them.

Top module: `bgwin_overlay`

## Requirements
- R1: With window k enabled and pix_row within [row_lo,row_hi] and pix_col within [col_lo,col_hi] (inclusive, character units), the output is out_valid=1 and out_rgb equal to that window's colour. Window k's fields sit at bits [k*W +: W] of each packed port, where W is the field width.
- R2: A window whose row start exceeds its row end, or whose column start exceeds its column end, produces neither body nor shadow pixels anywhere.
- R3: Where enabled window bodies overlap, the lowest window index wins. Window 0 has the highest priority and window 3 the lowest.
- R4: The frame pixel coordinate is X = pix_col*12 + pix_x and Y = pix_row*18 + pix_line. A shadow-enabled window casts a shadow equal to its body rectangle in (X,Y) shifted right by its shadow width. A shadow pixel shows shd_rgb with out_valid=1. Width code 0,1,2,3 selects 2,4,6,8 pixels.
- R5: The shadow rectangle is also shifted down by the shadow height. Height code 0,1,2,3 selects 2,4,6,8 lines.
- R6: The resolution order is body 0, shadow 0, body 1, shadow 1, and so on down to shadow 3. A body always covers its own shadow and the shadows of lower-priority windows. The shadow of a higher-priority window covers the bodies of lower-priority windows.
- R7: A window with its shadow-enable bit low casts no shadow, whatever its shadow codes are.
- R8: The enable bits reset to 0. en_load writes en_data (bit k is window k) at the clock edge. en_clear zeroes all enable bits at the edge and wins over en_load in the same cycle. A disabled window produces neither body nor shadow.
- R9: The outputs are registered. The result for the inputs present at clock edge n appears after edge n. When no window or shadow covers the pixel, out_valid=0 and out_rgb=000. Both outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_row | input | 4 | Character row of the current pixel |
| pix_col | input | 5 | Character column of the current pixel |
| pix_x | input | 4 | Pixel within the character cell, 0 to 11 |
| pix_line | input | 5 | Line within the character row, 0 to 17 |
| win_row_lo | input | 16 | Per-window first row |
| win_row_hi | input | 16 | Per-window last row |
| win_col_lo | input | 20 | Per-window first column |
| win_col_hi | input | 20 | Per-window last column |
| win_shd_en | input | 4 | Per-window shadow enable |
| win_rgb | input | 12 | Per-window body colour |
| win_shd_w | input | 8 | Per-window shadow width code |
| win_shd_h | input | 8 | Per-window shadow height code |
| shd_rgb | input | 3 | Colour shared by all shadows |
| en_load | input | 1 | Write en_data into the enable bits |
| en_data | input | 4 | New enable bits |
| en_clear | input | 1 | Zero all enable bits |
| out_valid | output | 1 | Pixel covered by a window or shadow |
| out_rgb | output | 3 | Colour of the covering window or shadow |

## Verification
Every colour and valid result is due one clock edge after the pixel position and window settings it depends on are presented. An enable load or clear takes effect for pixels sampled from the next edge onward. The bench has a behavioural model that evaluates the driven inputs at each rising edge against its own copy of the enable bits, and only then applies the load or clear. It compares the outputs with that expectation at the following falling edge. This keeps the one-cycle result latency and the one-cycle enable update in step without reading any internal signal.

// File: rtl/bgwin_pkg.sv
package bgwin_pkg;
   localparam int RGB_W  = 3;
   localparam int CODE_W = 2;

   typedef logic [RGB_W-1:0] rgb_t;

   // shadow reach from 2-bit code: 0->2, 1->4, 2->6, 3->8
   function automatic logic [3:0] shd_span(input logic [CODE_W-1:0] code);
      return {1'b0, code, 1'b0} + 4'd2;
   endfunction
endpackage

// File: rtl/bgwin_enables.sv
module bgwin_enables #(
   parameter int NWIN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_load,
   input  logic [NWIN-1:0] en_data,
   input  logic            en_clear,
   output logic [NWIN-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= '0;
      else if (en_clear) en_q <= '0;
      else if (en_load)  en_q <= en_data;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      en_clear |=> (en_q == '0)); // R8
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (en_load && !en_clear) |=> (en_q == $past(en_data))); // R8
endmodule

// File: rtl/bgwin_region.sv
module bgwin_region import bgwin_pkg::*; #(
   parameter int ROW_W   = 4,
   parameter int COL_W   = 5,
   parameter int CHAR_W  = 12,
   parameter int ROW_H   = 18,
   parameter int XW      = 10,
   parameter int YW      = 10,
   parameter bit SHADOWS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  pix_row,
   input  logic [COL_W-1:0]  pix_col,
   input  logic [XW-1:0]     cx,
   input  logic [YW-1:0]     cy,
   input  logic [ROW_W-1:0]  row_lo,
   input  logic [ROW_W-1:0]  row_hi,
   input  logic [COL_W-1:0]  col_lo,
   input  logic [COL_W-1:0]  col_hi,
   input  logic              en,
   input  logic              shd_en,
   input  logic [CODE_W-1:0] shd_w,
   input  logic [CODE_W-1:0] shd_h,
   output logic              body_hit,
   output logic              shd_hit
);
   localparam logic [XW-1:0] CW_X = XW'(CHAR_W);
   localparam logic [YW-1:0] RH_Y = YW'(ROW_H);

   // body test in character units: an inverted range matches nothing
   assign body_hit = en && (pix_row >= row_lo) && (pix_row <= row_hi)
                        && (pix_col >= col_lo) && (pix_col <= col_hi);

   generate
      if (SHADOWS) begin : g_shadow
         logic [XW-1:0] x_lo, x_hi;
         logic [YW-1:0] y_lo, y_hi;
         always_comb begin
            x_lo = XW'(col_lo) * CW_X + XW'(shd_span(shd_w));
            x_hi = XW'(col_hi) * CW_X + (CW_X - XW'(1)) + XW'(shd_span(shd_w));
            y_lo = YW'(row_lo) * RH_Y + YW'(shd_span(shd_h));
            y_hi = YW'(row_hi) * RH_Y + (RH_Y - YW'(1)) + YW'(shd_span(shd_h));
         end
         assign shd_hit = en && shd_en && (cx >= x_lo) && (cx <= x_hi)
                                       && (cy >= y_lo) && (cy <= y_hi);
      end else begin : g_no_shadow
         logic unused_shd;
         assign unused_shd = ^{cx, cy, shd_en, shd_w, shd_h};
         assign shd_hit    = 1'b0;
      end
   endgenerate

   logic ordered;
   assign ordered = (row_lo <= row_hi) && (col_lo <= col_hi);

   AST_INVERTED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !ordered |-> (!body_hit && !shd_hit)); // R2
endmodule

// File: rtl/bgwin_prio.sv
module bgwin_prio import bgwin_pkg::*; #(
   parameter int NWIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWIN-1:0]   body_hit,
   input  logic [NWIN-1:0]   shd_hit,
   input  logic [NWIN*RGB_W-1:0] win_rgb,
   input  rgb_t              shd_rgb,
   output logic              any_hit,
   output logic              shd_won,
   output rgb_t              sel_rgb
);
   localparam int NREQ = 2 * NWIN;
   localparam logic [NREQ-1:0] SHD_MASK = {NWIN{2'b10}};

   logic [NREQ-1:0] req, grant;

   // request order: body0, shadow0, body1, shadow1, ...
   always_comb begin
      for (int k = 0; k < NWIN; k++) begin
         req[2*k]   = body_hit[k];
         req[2*k+1] = shd_hit[k];
      end
   end

   assign grant   = req & (~req + NREQ'(1));
   assign any_hit = |req;
   assign shd_won = |(grant & SHD_MASK);

   always_comb begin
      sel_rgb = '0;
      for (int k = 0; k < NWIN; k++) begin
         if (grant[2*k])   sel_rgb |= win_rgb[k*RGB_W +: RGB_W];
         if (grant[2*k+1]) sel_rgb |= shd_rgb;
      end
   end

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R3
   AST_WINNER_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ($countones(grant) == 1)); // R6
endmodule

// File: rtl/bgwin_overlay.sv
module bgwin_overlay import bgwin_pkg::*; #(
   parameter int NWIN    = 4,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 5,
   parameter int PX_W    = 4,
   parameter int LN_W    = 5,
   parameter int CHAR_W  = 12,
   parameter int ROW_H   = 18,
   parameter bit SHADOWS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ROW_W-1:0]        pix_row,
   input  logic [COL_W-1:0]        pix_col,
   input  logic [PX_W-1:0]         pix_x,
   input  logic [LN_W-1:0]         pix_line,
   input  logic [NWIN*ROW_W-1:0]   win_row_lo,
   input  logic [NWIN*ROW_W-1:0]   win_row_hi,
   input  logic [NWIN*COL_W-1:0]   win_col_lo,
   input  logic [NWIN*COL_W-1:0]   win_col_hi,
   input  logic [NWIN-1:0]         win_shd_en,
   input  logic [NWIN*3-1:0]       win_rgb,
   input  logic [NWIN*2-1:0]       win_shd_w,
   input  logic [NWIN*2-1:0]       win_shd_h,
   input  logic [2:0]              shd_rgb,
   input  logic                    en_load,
   input  logic [NWIN-1:0]         en_data,
   input  logic                    en_clear,
   output logic                    out_valid,
   output logic [2:0]              out_rgb
);
   localparam int XW = COL_W + PX_W + 1;
   localparam int YW = ROW_W + LN_W + 1;

   generate
      if (NWIN < 1) begin : g_bad_nwin
         $error("bgwin_overlay: NWIN must be at least 1");
      end
      if (CHAR_W < 1 || CHAR_W > (1 << PX_W)) begin : g_bad_cw
         $error("bgwin_overlay: CHAR_W must fit in PX_W bits");
      end
      if (ROW_H < 1 || ROW_H > (1 << LN_W)) begin : g_bad_rh
         $error("bgwin_overlay: ROW_H must fit in LN_W bits");
      end
   endgenerate

   logic [XW-1:0] cx;
   logic [YW-1:0] cy;
   assign cx = XW'(pix_col) * XW'(CHAR_W) + XW'(pix_x);
   assign cy = YW'(pix_row) * YW'(ROW_H)  + YW'(pix_line);

   logic [NWIN-1:0] en_q, body_hit, shd_hit;

   bgwin_enables #(.NWIN(NWIN)) u_en (
      .clk(clk), .rst_n(rst_n), .en_load(en_load), .en_data(en_data),
      .en_clear(en_clear), .en_q(en_q)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NWIN; gi++) begin : g_win
         bgwin_region #(
            .ROW_W(ROW_W), .COL_W(COL_W), .CHAR_W(CHAR_W), .ROW_H(ROW_H),
            .XW(XW), .YW(YW), .SHADOWS(SHADOWS)
         ) u_reg (
            .clk(clk), .rst_n(rst_n),
            .pix_row(pix_row), .pix_col(pix_col), .cx(cx), .cy(cy),
            .row_lo(win_row_lo[gi*ROW_W +: ROW_W]),
            .row_hi(win_row_hi[gi*ROW_W +: ROW_W]),
            .col_lo(win_col_lo[gi*COL_W +: COL_W]),
            .col_hi(win_col_hi[gi*COL_W +: COL_W]),
            .en(en_q[gi]), .shd_en(win_shd_en[gi]),
            .shd_w(win_shd_w[gi*CODE_W +: CODE_W]),
            .shd_h(win_shd_h[gi*CODE_W +: CODE_W]),
            .body_hit(body_hit[gi]), .shd_hit(shd_hit[gi])
         );
      end
   endgenerate

   logic any_hit, shd_won;
   rgb_t sel_rgb;

   bgwin_prio #(.NWIN(NWIN)) u_prio (
      .clk(clk), .rst_n(rst_n), .body_hit(body_hit), .shd_hit(shd_hit),
      .win_rgb(win_rgb), .shd_rgb(shd_rgb), .any_hit(any_hit),
      .shd_won(shd_won), .sel_rgb(sel_rgb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= any_hit;
         out_rgb   <= any_hit ? sel_rgb : '0;
      end
   end

   AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_rgb == 3'b000)); // R9
   AST_NO_EN_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> !out_valid); // R8
   AST_SHADOW_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
      shd_won |=> (out_valid && out_rgb == $past(shd_rgb))); // R4
endmodule

// File: tb/sim_bgwin_overlay.sv
`timescale 1ns/1ps
module sim_bgwin_overlay;
   localparam int NW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [3:0]  pix_row = '0;
   logic [4:0]  pix_col = '0;
   logic [3:0]  pix_x = '0;
   logic [4:0]  pix_line = '0;
   logic [15:0] win_row_lo, win_row_hi;
   logic [19:0] win_col_lo, win_col_hi;
   logic [3:0]  win_shd_en;
   logic [11:0] win_rgb;
   logic [7:0]  win_shd_w, win_shd_h;
   logic [2:0]  shd_rgb;
   logic        en_load = 1'b0, en_clear = 1'b0;
   logic [3:0]  en_data = '0;
   logic        out_valid;
   logic [2:0]  out_rgb;

   int c_rlo[NW], c_rhi[NW], c_clo[NW], c_chi[NW];
   int c_rgb[NW], c_se[NW], c_w[NW], c_h[NW];
   int c_shd;

   always_comb begin
      for (int i = 0; i < NW; i++) begin
         win_row_lo[i*4 +: 4] = 4'(c_rlo[i]);
         win_row_hi[i*4 +: 4] = 4'(c_rhi[i]);
         win_col_lo[i*5 +: 5] = 5'(c_clo[i]);
         win_col_hi[i*5 +: 5] = 5'(c_chi[i]);
         win_rgb[i*3 +: 3]    = 3'(c_rgb[i]);
         win_shd_en[i]        = c_se[i] != 0;
         win_shd_w[i*2 +: 2]  = 2'(c_w[i]);
         win_shd_h[i*2 +: 2]  = 2'(c_h[i]);
      end
      shd_rgb = 3'(c_shd);
   end

   bgwin_overlay u0 (
      .clk(clk), .rst_n(rst_n), .pix_row(pix_row), .pix_col(pix_col),
      .pix_x(pix_x), .pix_line(pix_line), .win_row_lo(win_row_lo),
      .win_row_hi(win_row_hi), .win_col_lo(win_col_lo), .win_col_hi(win_col_hi),
      .win_shd_en(win_shd_en), .win_rgb(win_rgb), .win_shd_w(win_shd_w),
      .win_shd_h(win_shd_h), .shd_rgb(shd_rgb), .en_load(en_load),
      .en_data(en_data), .en_clear(en_clear), .out_valid(out_valid),
      .out_rgb(out_rgb)
   );

   int n_checks = 0, n_fail = 0;
   string phase_req = "R9";
   bit done = 1'b0;

   // behavioural reference
   logic [3:0] m_en = '0;
   logic       exp_v = 1'b0;
   logic [2:0] exp_rgb = '0;
   int         exp_r, exp_c, exp_px, exp_ln;

   function automatic void ref_px(input int r, c, px, ln,
                                  output logic v, output logic [2:0] col);
      int x, y, w, h;
      x = c * 12 + px;
      y = r * 18 + ln;
      v = 1'b0;
      col = 3'd0;
      for (int i = 0; i < NW; i++) begin
         if (!m_en[i]) continue;
         if (r >= c_rlo[i] && r <= c_rhi[i] && c >= c_clo[i] && c <= c_chi[i]) begin
            v = 1'b1; col = 3'(c_rgb[i]); return;
         end
         if (c_se[i] != 0) begin
            w = 2 * (c_w[i] + 1);
            h = 2 * (c_h[i] + 1);
            if (x >= c_clo[i]*12 + w && x <= c_chi[i]*12 + 11 + w &&
                y >= c_rlo[i]*18 + h && y <= c_rhi[i]*18 + 17 + h) begin
               v = 1'b1; col = 3'(c_shd); return;
            end
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = '0; exp_v = 1'b0; exp_rgb = '0;
      end else begin
         exp_r = pix_row; exp_c = pix_col; exp_px = pix_x; exp_ln = pix_line;
         ref_px(exp_r, exp_c, exp_px, exp_ln, exp_v, exp_rgb);
         if (en_clear)     m_en = '0;
         else if (en_load) m_en = en_data;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (out_valid !== exp_v || out_rgb !== exp_rgb) begin
            n_fail++;
            $display("FAIL %s at row=%0d col=%0d x=%0d line=%0d: valid=%0b rgb=%0d expected valid=%0b rgb=%0d",
                     phase_req, exp_r, exp_c, exp_px, exp_ln, out_valid, out_rgb, exp_v, exp_rgb);
         end
      end
   end

   task automatic set_win(input int i, rlo, rhi, clo, chi, rgb, se, w, h);
      @(negedge clk);
      c_rlo[i] = rlo; c_rhi[i] = rhi; c_clo[i] = clo; c_chi[i] = chi;
      c_rgb[i] = rgb; c_se[i] = se; c_w[i] = w; c_h[i] = h;
   endtask

   task automatic ctl(input bit ld, input logic [3:0] d, input bit clr);
      @(negedge clk);
      en_load = ld; en_data = d; en_clear = clr;
      pix_row = 4'($urandom_range(15)); pix_col = 5'($urandom_range(31));
      pix_x = 4'($urandom_range(11)); pix_line = 5'($urandom_range(17));
   endtask

   task automatic burst(input int n, r0, r1, c0, c1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         en_load = 1'b0; en_clear = 1'b0;
         pix_row  = 4'($urandom_range(r1, r0));
         pix_col  = 5'($urandom_range(c1, c0));
         pix_x    = 4'($urandom_range(11));
         pix_line = 5'($urandom_range(17));
      end
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) begin
         c_rlo[i] = 0; c_rhi[i] = 0; c_clo[i] = 0; c_chi[i] = 0;
         c_rgb[i] = 0; c_se[i] = 0; c_w[i] = 0; c_h[i] = 0;
      end
      c_shd = 7;
      // R9: reset state, then nothing enabled
      phase_req = "R9";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      burst(200, 0, 15, 0, 31);

      // R1: single body
      phase_req = "R1";
      set_win(0, 2, 5, 3, 10, 5, 0, 0, 0);
      ctl(1'b1, 4'b0001, 1'b0);
      burst(1500, 0, 8, 0, 14);

      // R3: overlapping bodies, fixed priority
      phase_req = "R3";
      set_win(1, 4, 8, 8, 15, 2, 0, 0, 0);
      set_win(2, 0, 3, 0, 5, 3, 0, 0, 0);
      set_win(3, 6, 10, 12, 20, 6, 0, 0, 0);
      ctl(1'b1, 4'b1111, 1'b0);
      burst(2500, 0, 12, 0, 22);

      // R4: shadow width codes
      phase_req = "R4";
      ctl(1'b1, 4'b0001, 1'b0);
      for (int cd = 0; cd < 4; cd++) begin
         set_win(0, 2, 5, 3, 10, 5, 1, cd, 0);
         burst(800, 1, 7, 2, 12);
      end

      // R5: shadow height codes
      phase_req = "R5";
      for (int cd = 0; cd < 4; cd++) begin
         set_win(0, 2, 5, 3, 10, 5, 1, 0, cd);
         burst(800, 4, 7, 2, 12);
      end

      // R6: shadows against bodies of other windows
      phase_req = "R6";
      c_shd = 6;
      set_win(0, 2, 4, 2, 6, 1, 1, 3, 3);
      set_win(1, 3, 6, 5, 9, 4, 1, 1, 2);
      set_win(2, 5, 7, 0, 3, 3, 1, 2, 1);
      ctl(1'b1, 4'b0111, 1'b0);
      burst(3000, 1, 8, 0, 11);

      // R7: shadow enable off with large codes
      phase_req = "R7";
      set_win(0, 2, 4, 2, 6, 1, 0, 3, 3);
      set_win(1, 3, 6, 5, 9, 4, 0, 3, 3);
      set_win(2, 5, 7, 0, 3, 3, 0, 3, 3);
      burst(1500, 1, 8, 0, 11);

      // R2: inverted bounds produce nothing
      phase_req = "R2";
      set_win(0, 6, 3, 2, 8, 1, 1, 3, 3);
      set_win(1, 1, 3, 9, 4, 4, 1, 2, 2);
      set_win(2, 9, 10, 0, 2, 3, 1, 0, 0);
      burst(2000, 0, 12, 0, 14);

      // R8: enable load / clear / clear-over-load
      phase_req = "R8";
      set_win(0, 0, 15, 0, 31, 2, 0, 0, 0);
      set_win(1, 0, 7, 0, 15, 5, 0, 0, 0);
      set_win(2, 8, 15, 16, 31, 3, 0, 0, 0);
      ctl(1'b1, 4'b0001, 1'b0);
      burst(50, 0, 15, 0, 31);
      ctl(1'b0, 4'b0000, 1'b1);
      burst(50, 0, 15, 0, 31);
      ctl(1'b1, 4'b1111, 1'b1);
      burst(50, 0, 15, 0, 31);
      for (int k = 0; k < 400; k++) begin
         ctl(1'($urandom_range(1)), 4'($urandom_range(15)), ($urandom_range(3) == 0));
         burst(4, 0, 15, 0, 31);
      end
      ctl(1'b0, 4'b0000, 1'b0);
      @(negedge clk);
      finish_run();
   end
endmodule